// File: doc/BRIEF.md
# Real-Time-Clock Register File

This block is the register side of a PC-style CMOS clock. It holds the calendar and time-of-day bytes and the general-purpose bytes that sit between them below the first status register. It also holds four status registers: a rate/time-base control register (A), a mode/enable register (B) and two flag registers (C, D) that always read as zero. A single byte-wide port with one shared address, a write strobe and a read strobe reaches every register. Read data is registered and appears one cycle after the read strobe. While reset is held, the time and calendar bytes are loaded from a preset port. The year is stored either as a plain binary count or as a two-digit BCD value.

Reading register A flips its update-in-progress bit (bit 7) as a side effect. Software that polls that bit therefore sees it alternate. Bit 6 of register B enables the periodic interrupt. A small timer state machine with two states, `TMR_IDLE` and `TMR_RUN`, raises a one-cycle `irq` pulse every `TICK_CYCLES` clocks while it runs. It leaves reset in `TMR_RUN` with its count at zero. It takes the transition `TMR_IDLE -> TMR_RUN` (count restarted at zero) when register B is written with bit 6 set. It takes the transition `TMR_RUN -> TMR_IDLE` when register B is written with bit 6 clear. A write with bit 6 set while in `TMR_RUN` keeps the state and does not disturb the count.

Top module: `rtc_regfile`

## Requirements
- R1: Addresses 0x00 to 0x09 are plain byte storage: a write stores `wr_data` and a later read of the same address returns it unchanged.
- R2: While `rst_n` is low, the storage bytes load seconds at 0x00, minutes at 0x02, hours at 0x04, day of week at 0x06 (stored as `preset_wday0`+1, so 1 means Sunday), day of month at 0x07 and month at 0x08 (stored as `preset_mon0`+1, range 1 to 12). Bytes 0x01, 0x03 and 0x05 load 0x00.
- R3: The year byte at 0x09 loads `preset_year` (years since 1900) unchanged when `preset_bcd` is 0. When `preset_bcd` is 1 it loads `preset_year` modulo 100, with the tens digit in bits 7:4 and the ones digit in bits 3:0.
- R4: Reset puts 0x26 in register A (0x0A) and 0x46 in register B (0x0B). The value 0x46 means periodic enable, binary mode (bit 2) and 24-hour mode (bit 1).
- R5: Each accepted read of register A inverts bit 7 of the stored value and returns the inverted value, so back-to-back reads alternate bit 7.
- R6: Reads of addresses 0x0C, 0x0D, 0x0E and 0x0F return 0x00, and writes to them have no effect.
- R7: A read is accepted only when `rd_en` is 1 and `wr_en` is 0. Its data is on `rd_data` in the cycle after the strobe. `rd_data` holds its value in every other cycle, and it is 0x00 after reset. When both strobes are high, only the write takes place.
- R8: A write to register B stores all 8 bits. If bit 6 is set and the timer is idle, the timer starts with its count at zero. If bit 6 is clear, the timer stops and `irq` stays 0.
- R9: While the timer runs, `irq` is high for exactly one cycle in every `TICK_CYCLES` cycles. A write to B with bit 6 set while the timer runs does not change this spacing.
- R10: After reset is released, the first `irq` pulse comes in the `TICK_CYCLES`-th cycle, counting the first cycle after the last reset edge as one. The same timing holds after the timer is started by a write to B.
- R11: A write to register A stores all 8 bits, and a following read returns that value with bit 7 inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the preset values |
| addr | input | ADDR_W | Shared register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| preset_bcd | input | 1 | Year is stored in BCD when 1 |
| preset_year | input | 8 | Years since 1900 |
| preset_mon0 | input | 4 | Month, 0 to 11 |
| preset_mday | input | 8 | Day of month |
| preset_hour | input | 8 | Hours |
| preset_min | input | 8 | Minutes |
| preset_sec | input | 8 | Seconds |
| preset_wday0 | input | 3 | Day of week, 0 = Sunday |
| irq | output | 1 | One-cycle periodic interrupt pulse |

## Verification
The hardest case to reach is the timer phase across writes to register B. A re-enable while running must leave the count alone, while an enable from idle must restart it at zero, and these two cases look the same at the ports except for the spacing of later pulses. The stimulus first stops the timer and watches that no pulse appears for several periods. It then starts the timer and measures the cycles to the first pulse. Finally it writes the enable again partway through a period and measures that the next pulse still arrives on the original schedule. A behavioural model of the counter follows every clock, so any phase slip shows up as a mismatch on `irq`.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    // register map (software-visible order)
    localparam int IDX_SEC  = 0;
    localparam int IDX_MIN  = 2;
    localparam int IDX_HOUR = 4;
    localparam int IDX_WDAY = 6;
    localparam int IDX_MDAY = 7;
    localparam int IDX_MON  = 8;
    localparam int IDX_YEAR = 9;
    localparam int IDX_A    = 10;
    localparam int IDX_B    = 11;
    localparam int IDX_C    = 12;
    localparam int IDX_D    = 13;

    localparam int BIT_UIP  = 7;
    localparam int BIT_PIE  = 6;

    localparam logic [7:0] A_RESET = 8'h26;
    localparam logic [7:0] B_RESET = 8'h46;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    function automatic logic [7:0] year_code(input logic [7:0] yr, input logic bcd);
        logic [7:0] rem;
        logic [7:0] tens;
        logic [7:0] ones;
        rem  = yr % 8'd100;
        tens = rem / 8'd10;
        ones = rem - tens * 8'd10;
        return bcd ? {tens[3:0], ones[3:0]} : yr;
    endfunction

endpackage

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
    parameter int N_BYTES = 10,
    parameter int ADDR_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [7:0]              wr_data,
    input  logic [N_BYTES-1:0][7:0] init,
    output logic [7:0]              rd_byte
);

    logic [7:0] byte_q [N_BYTES];

    for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= init[g];
            end else if (wr_en && addr == ADDR_W'(g)) begin
                q <= wr_data;
            end
        end
        assign byte_q[g] = q;
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < N_BYTES; i++) begin
            if (addr == ADDR_W'(i)) begin
                rd_byte = byte_q[i];
            end
        end
    end

endmodule

// File: rtl/rtc_tick_fsm.sv
module rtc_tick_fsm
    import rtc_pkg::*;
#(
    parameter int TICK_CYCLES = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic irq
);

    localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    tmr_state_e state_q;
    tmr_state_e state_d;
    logic [CW-1:0] cnt_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_IDLE: if (start) state_d = TMR_RUN;
            TMR_RUN:  if (stop)  state_d = TMR_IDLE;
            default:             state_d = TMR_IDLE;
        endcase
    end

    // state register and interval count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TMR_IDLE || state_d == TMR_IDLE) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        irq = (state_q == TMR_RUN) && (cnt_q == LAST);
    end

    // R9
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R8
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !irq);

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int TICK_CYCLES = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    input  logic              preset_bcd,
    input  logic [7:0]        preset_year,
    input  logic [3:0]        preset_mon0,
    input  logic [7:0]        preset_mday,
    input  logic [7:0]        preset_hour,
    input  logic [7:0]        preset_min,
    input  logic [7:0]        preset_sec,
    input  logic [2:0]        preset_wday0,
    output logic              irq
);

    localparam int N_STORE = IDX_A;
    localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(IDX_A);
    localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(IDX_B);
    localparam logic [ADDR_W-1:0] ADR_C = ADDR_W'(IDX_C);
    localparam logic [ADDR_W-1:0] ADR_D = ADDR_W'(IDX_D);

    logic [N_STORE-1:0][7:0] init;
    logic [7:0] store_byte;
    logic [7:0] reg_a;
    logic [7:0] reg_b;
    logic [7:0] rd_mux;
    logic       is_store;
    logic       rd_acc;
    logic       wr_b;

    assign is_store = (addr < ADDR_W'(N_STORE));
    assign rd_acc   = rd_en && !wr_en;
    assign wr_b     = wr_en && (addr == ADR_B);

    always_comb begin
        init            = '0;
        init[IDX_SEC]   = preset_sec;
        init[IDX_MIN]   = preset_min;
        init[IDX_HOUR]  = preset_hour;
        init[IDX_WDAY]  = {5'b0, preset_wday0} + 8'd1;
        init[IDX_MDAY]  = preset_mday;
        init[IDX_MON]   = {4'b0, preset_mon0} + 8'd1;
        init[IDX_YEAR]  = year_code(preset_year, preset_bcd);
    end

    rtc_byte_store #(
        .N_BYTES (N_STORE),
        .ADDR_W  (ADDR_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && is_store),
        .addr    (addr),
        .wr_data (wr_data),
        .init    (init),
        .rd_byte (store_byte)
    );

    rtc_tick_fsm #(
        .TICK_CYCLES (TICK_CYCLES)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_b && wr_data[BIT_PIE]),
        .stop  (wr_b && !wr_data[BIT_PIE]),
        .irq   (irq)
    );

    always_comb begin
        if (is_store)            rd_mux = store_byte;
        else if (addr == ADR_B)  rd_mux = reg_b;
        else                     rd_mux = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_a   <= A_RESET;
            reg_b   <= B_RESET;
            rd_data <= 8'h00;
        end else if (wr_en) begin
            if (addr == ADR_A) reg_a <= wr_data;
            if (addr == ADR_B) reg_b <= wr_data;
        end else if (rd_en) begin
            if (addr == ADR_A) begin
                reg_a[BIT_UIP]   <= ~reg_a[BIT_UIP];
                rd_data          <= reg_a;
                rd_data[BIT_UIP] <= ~reg_a[BIT_UIP];
            end else begin
                rd_data <= rd_mux;
            end
        end
    end

    // R5
    uip_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && addr == ADR_A) ##1 (rd_acc && addr == ADR_A)
        |=> rd_data[BIT_UIP] != $past(rd_data[BIT_UIP]));

    // R6
    flags_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && (addr == ADR_C || addr == ADR_D)) |=> rd_data == 8'h00);

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(rd_data));

    // R8
    pie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b && !wr_data[BIT_PIE]) ##1 !wr_b |=> !irq);

endmodule

// File: tb/rtc_regfile_test.sv
module rtc_regfile_test;

    localparam int P = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       preset_bcd = 1'b1;
    logic [7:0] preset_year = 8'd124;
    logic [3:0] preset_mon0 = 4'd5;
    logic [7:0] preset_mday = 8'd17;
    logic [7:0] preset_hour = 8'd13;
    logic [7:0] preset_min = 8'd45;
    logic [7:0] preset_sec = 8'd30;
    logic [2:0] preset_wday0 = 3'd2;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rtc_regfile #(.ADDR_W(4), .TICK_CYCLES(P)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .preset_bcd(preset_bcd), .preset_year(preset_year),
        .preset_mon0(preset_mon0), .preset_mday(preset_mday),
        .preset_hour(preset_hour), .preset_min(preset_min),
        .preset_sec(preset_sec), .preset_wday0(preset_wday0), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int    m_mem [16];
    int    m_a, m_b, m_rd, m_cnt;
    bit    m_run, m_live, m_a_seen;
    string m_tag = "R7";

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_mem[i] = 0;
            m_mem[0] = preset_sec;
            m_mem[2] = preset_min;
            m_mem[4] = preset_hour;
            m_mem[6] = preset_wday0 + 1;
            m_mem[7] = preset_mday;
            m_mem[8] = preset_mon0 + 1;
            m_mem[9] = preset_bcd ? (((preset_year % 100) / 10) * 16 + (preset_year % 10))
                                  : preset_year;
            m_a = 'h26; m_b = 'h46; m_rd = 0; m_tag = "R7";
            m_run = 1; m_cnt = 0; m_live = 0; m_a_seen = 0;
        end else begin
            m_live = 1;
            if (wr_en) begin
                if (addr < 10) m_mem[addr] = wr_data;
                else if (addr == 10) m_a = wr_data;
                else if (addr == 11) m_b = wr_data;
                if (addr == 11) begin
                    if (wr_data[6]) begin
                        if (!m_run) begin m_run = 1; m_cnt = 0; end
                        else m_cnt = (m_cnt + 1) % P;
                    end else begin
                        m_run = 0; m_cnt = 0;
                    end
                end else if (m_run) m_cnt = (m_cnt + 1) % P;
                if (rd_en) m_tag = "R7";
            end else begin
                if (rd_en) begin
                    if (addr < 10) begin m_rd = m_mem[addr]; m_tag = "R1"; end
                    else if (addr == 10) begin
                        m_a = m_a ^ 'h80; m_rd = m_a;
                        m_tag = m_a_seen ? "R5" : "R4"; m_a_seen = 1;
                    end
                    else if (addr == 11) begin m_rd = m_b; m_tag = "R8"; end
                    else begin m_rd = 0; m_tag = "R6"; end
                end
                if (m_run) m_cnt = (m_cnt + 1) % P;
            end
        end
    end

    always @(negedge clk) begin
        if (m_live) begin
            chk({"R9 irq model ", m_tag}, irq, (m_run && m_cnt == P - 1) ? 1 : 0);
            chk({m_tag, " rd_data model"}, rd_data, m_rd);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int a, input int d);
        addr = 4'(a); wr_data = 8'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a);
        addr = 4'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    // count negedges until irq is seen high
    task automatic wait_irq(output int n);
        n = 0;
        while (!irq && n < 10 * P) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int n;
        int highs;
        @(negedge clk);
        do_reset();
        chk("R7 rd_data after reset", rd_data, 0);

        // R10: first pulse out of reset
        wait_irq(n);
        chk("R10 first pulse after reset", n, P - 1);
        @(negedge clk);
        chk("R9 pulse one cycle wide", irq, 0);

        // R2 / R3 / R4 reset contents
        rd(0);  chk("R2 seconds", rd_data, 30);
        rd(1);  chk("R2 gap byte", rd_data, 0);
        rd(2);  chk("R2 minutes", rd_data, 45);
        rd(4);  chk("R2 hours", rd_data, 13);
        rd(6);  chk("R2 weekday", rd_data, 3);
        rd(7);  chk("R2 mday", rd_data, 17);
        rd(8);  chk("R2 month", rd_data, 6);
        rd(9);  chk("R3 bcd year", rd_data, 'h24);
        rd(11); chk("R4 reg B reset", rd_data, 'h46);
        rd(10); chk("R4 reg A reset (uip inverted)", rd_data, 'hA6);
        rd(10); chk("R5 second A read", rd_data, 'h26);
        rd(10); chk("R5 third A read", rd_data, 'hA6);

        // R6 flags and unmapped addresses
        rd(12); chk("R6 reg C", rd_data, 0);
        wr(13, 'hFF);
        rd(13); chk("R6 reg D after write", rd_data, 0);
        wr(15, 'h77);
        rd(15); chk("R6 addr 0xF", rd_data, 0);

        // R1 storage
        wr(3, 'h5A);
        wr(0, 'hC3);
        rd(3); chk("R1 byte 3", rd_data, 'h5A);
        rd(0); chk("R1 byte 0", rd_data, 'hC3);
        wr(9, 'h99);
        rd(9); chk("R1 byte 9", rd_data, 'h99);

        // R7 simultaneous strobes: write only
        addr = 4'd5; wr_data = 8'h3C; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R7 read ignored during write", rd_data, 'h99);
        rd(5); chk("R7 write took effect", rd_data, 'h3C);

        // R11 write A
        wr(10, 'h55);
        rd(10); chk("R11 reg A written", rd_data, 'hD5);

        // R8 stop timer
        wr(11, 'h06);
        rd(11); chk("R8 reg B stored", rd_data, 'h06);
        highs = 0;
        for (int i = 0; i < 3 * P; i++) begin
            @(negedge clk);
            if (irq) highs++;
        end
        chk("R8 no pulse while disabled", highs, 0);

        // R8 / R10 start timer from idle
        wr(11, 'h46);
        wait_irq(n);
        chk("R10 first pulse after enable", n, P - 1);
        // R9 re-enable mid-run keeps phase
        idle(3);
        wr(11, 'h4E);
        wait_irq(n);
        chk("R9 re-enable keeps spacing", n, P - 4);
        @(negedge clk);
        wait_irq(n);
        chk("R9 pulse spacing", n, P - 1);

        // R3 binary year after a second reset
        preset_bcd = 1'b0;
        do_reset();
        rd(9); chk("R3 binary year", rd_data, 124);
        preset_bcd = 1'b1; preset_year = 8'd99;
        do_reset();
        rd(9); chk("R3 bcd year 99", rd_data, 'h99);
        rd(10); chk("R4 reg A after second reset", rd_data, 'hA6);

        idle(2);
        summary();
        $finish;
    end

endmodule